// File: doc/BRIEF.md
# Serial Receive Path with Sticky Status Flags

This block receives asynchronous serial bytes on a single RX line and collects them into a small receive buffer of one to four bytes. The line is brought into the clock domain through a two-flop synchroniser and sampled with a 16x oversampling tick. Each bit is taken at its middle, and a start bit is only accepted if the line is still low half a bit after the falling edge. An optional even parity bit and the stop bit are checked for every byte.

Alongside the data path the block keeps a status word of sticky flags: buffer ready, framing error, overrun, line stuck low, wake-up, one parity flag per buffer slot, and a live copy of the synchronised RX level. Software reads the buffer once the ready flag is up and releases it by writing a one to that flag's bit. Every sticky flag is cleared the same way. Three interrupt outputs combine the flags with their enable inputs. An init input clears the ready and wake-up flags and restarts filling at the first slot. A sleep input arms wake-up detection on a falling RX edge.

Top module: `uart_rx_monitor`

## Requirements
- R1: With default parameters, `status_o` is 10 bits wide. Bit 0 is ready, bit 1 framing error, bit 2 overrun, bit 3 stuck-low, bit 4 wake-up, bit 5 the synchronised RX level, and bits 6+k the parity flag of slot k. After reset the word reads 0x020 while RX is idle high. Bit 5 follows RX after the two-flop synchroniser.
- R2: A frame is a low start bit, 8 data bits LSB first, an optional parity bit, and a high stop bit, each lasting 16 ticks of `os_tick_i`. Each bit is sampled mid-bit. A low pulse shorter than half a bit is not taken as a start and stores nothing.
- R3: The buffer holds `len_i`+1 bytes. Slot k appears on `data_o[8k+7:8k]`, with the first byte of a batch in slot 0. Ready (bit 0) sets when the last configured slot is written, and not earlier.
- R4: A byte whose stop bit is sampled low sets the framing flag (bit 1). The byte is still stored.
- R5: With `par_en_i` high, parity is even: the parity bit equals the XOR of the 8 data bits. A mismatch sets the parity flag of the slot the byte is written to (bit 6+k). Parity flags never raise an interrupt.
- R6: A byte completed while ready is set raises the overrun flag (bit 2). With `lock_i` high the byte is dropped and the buffer is unchanged. With `lock_i` low the byte overwrites the buffer from slot 0 onward and ready stays set.
- R7: When RX stays low for more than 100 bit times (1600 ticks), the stuck-low flag (bit 3) sets once. It does not set again until RX has gone high and then stays low for that long again.
- R8: While `sleep_i` is high, a falling edge of the synchronised RX sets the wake-up flag (bit 4), and `irq_wake_o` equals the flag AND `wake_ie_i`. Outside sleep, no edge sets the flag.
- R9: While `init_i` is high, ready and wake-up are held clear, no byte is stored, and the next batch fills from slot 0.
- R10: Writing a 1 to a bit of `clr_i` clears that sticky flag. If a hardware set lands in the same cycle as the clear, the set wins.
- R11: `irq_rx_o` is ready AND `rx_ie_i`. `irq_err_o` is (framing OR overrun OR stuck-low) AND `err_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line |
| os_tick_i | input | 1 | Oversampling tick, 16 per bit time |
| init_i | input | 1 | Init mode: clears ready and wake-up, restarts buffer fill |
| sleep_i | input | 1 | Sleep mode: arms wake-up edge detection |
| par_en_i | input | 1 | Expect an even parity bit after the data bits |
| len_i | input | 2 | Buffer length minus one |
| lock_i | input | 1 | On overrun, drop the new byte instead of overwriting |
| rx_ie_i | input | 1 | Enable for the buffer-ready interrupt |
| err_ie_i | input | 1 | Enable for the error interrupt |
| wake_ie_i | input | 1 | Enable for the wake-up interrupt |
| clr_i | input | 10 | Write-one-to-clear strobes, one per status bit |
| status_o | output | 10 | Status word |
| data_o | output | 32 | Receive buffer, slot k in bits 8k+7:8k |
| irq_rx_o | output | 1 | Buffer-ready interrupt |
| irq_err_o | output | 1 | Framing, overrun or stuck-low interrupt |
| irq_wake_o | output | 1 | Wake-up interrupt |

## Verification
A hardware set of a sticky flag can land in the same cycle as the software strobe that clears it. The bench provokes this by holding the framing-error clear bit high throughout a frame with a bad stop bit, so the strobe is certainly present in the set cycle. With set-over-clear priority the flag must show high for at least one cycle before the held strobe removes it. A monitor watching the status word on every cycle judges this. A second pairing, a byte arriving while the buffer is still marked ready, is checked for both the lock policy and the overwrite policy against the buffer contents.

// File: rtl/urxm_pkg.sv
package urxm_pkg;

    // status word bit positions
    localparam int ST_RDY  = 0;
    localparam int ST_FRM  = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_SZ   = 3;
    localparam int ST_WAKE = 4;
    localparam int ST_PIN  = 5;
    localparam int ST_PAR0 = 6;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
    } rx_byte_t;

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/urxm_sampler.sv
module urxm_sampler
    import urxm_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_s,
    input  logic     par_en,
    output rx_byte_t byte_o,
    output logic     byte_v_o
);
    localparam int CW = $clog2(OS);
    localparam logic [CW-1:0] HALF = CW'(OS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    rx_state_e      st;
    logic [CW-1:0]  cnt;
    logic [2:0]     bitn;
    logic [7:0]     shreg;
    logic           perr;

    always_ff @(posedge clk) begin
        byte_v_o <= 1'b0;
        if (rst) begin
            st     <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            perr   <= 1'b0;
            byte_o <= '0;
        end else if (tick) begin
            case (st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == HALF) begin
                        cnt  <= '0;
                        bitn <= '0;
                        perr <= 1'b0;
                        st   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= par_en ? RX_PAR : RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        perr <= rx_s ^ even_par(shreg);
                        st   <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        byte_v_o <= 1'b1;
                        byte_o   <= '{data: shreg, par_err: perr, frm_err: !rx_s};
                        st       <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R2: a completed frame is a single-cycle event, never back to back
    p_byte_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        byte_v_o |=> !byte_v_o);

endmodule

// File: rtl/urxm_watch.sv
module urxm_watch #(
    parameter int OS         = 16,
    parameter int STUCK_BITS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_s,
    input  logic sleep,
    output logic sz_set_o,
    output logic wake_set_o
);
    localparam int LIMIT = OS * STUCK_BITS;
    localparam int NW    = $clog2(LIMIT + 2);

    logic [NW-1:0] low_cnt;
    logic          rx_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            rx_prev <= 1'b1;
        end else begin
            rx_prev <= rx_s;
            if (rx_s)
                low_cnt <= '0;
            else if (tick && low_cnt <= NW'(LIMIT))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign sz_set_o   = tick && !rx_s && (low_cnt == NW'(LIMIT));
    assign wake_set_o = sleep && rx_prev && !rx_s;

    // R7: the stuck-low event fires once per low period
    p_sz_single_r7: assert property (@(posedge clk) disable iff (rst)
        sz_set_o |=> !sz_set_o);

endmodule

// File: rtl/urxm_buffer.sv
module urxm_buffer
    import urxm_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int IW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init,
    input  logic                  byte_v,
    input  rx_byte_t              byte_i,
    input  logic [IW-1:0]         len_i,
    input  logic                  lock_i,
    input  logic                  clr_rdy,
    input  logic                  clr_ovr,
    input  logic [NBYTES-1:0]     clr_par,
    output logic                  rdy_o,
    output logic                  ovr_o,
    output logic [NBYTES-1:0]     par_o,
    output logic [8*NBYTES-1:0]   data_o
);
    logic [NBYTES-1:0][7:0] slots;
    logic [IW-1:0]          wr_idx;
    logic [IW-1:0]          last;
    logic                   rdy_q, ovr_q;
    logic [NBYTES-1:0]      par_q, par_set;
    logic                   store, fill_done, ovr_set;

    assign last      = (len_i >= IW'(NBYTES - 1)) ? IW'(NBYTES - 1) : len_i;
    assign store     = byte_v && !init && (!rdy_q || !lock_i);
    assign fill_done = store && !rdy_q && (wr_idx == last);
    assign ovr_set   = byte_v && !init && rdy_q;

    for (genvar k = 0; k < NBYTES; k++) begin : g_par
        assign par_set[k] = store && byte_i.par_err && (wr_idx == IW'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots  <= '0;
            wr_idx <= '0;
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= '0;
        end else begin
            if (store) slots[wr_idx] <= byte_i.data;
            par_q <= (par_q & ~clr_par) | par_set;
            ovr_q <= (ovr_q & ~clr_ovr) | ovr_set;
            if (init) begin
                rdy_q  <= 1'b0;
                wr_idx <= '0;
            end else begin
                rdy_q <= (rdy_q & ~clr_rdy) | fill_done;
                if (store) wr_idx <= (wr_idx == last) ? '0 : wr_idx + 1'b1;
            end
        end
    end

    assign rdy_o  = rdy_q;
    assign ovr_o  = ovr_q;
    assign par_o  = par_q;
    assign data_o = slots;

    // R9: init holds the buffer released
    p_init_rdy_r9: assert property (@(posedge clk) disable iff (rst)
        init |=> !rdy_q);
    // R6: a byte on a full buffer raises overrun
    p_ovr_set_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_v && !init && rdy_q) |=> ovr_q);
    // R6: lock mode leaves the buffer untouched
    p_lock_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_v && rdy_q && lock_i) |=> $stable(slots));
    // R10: completion wins over a same-cycle release
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (byte_v && !init && !rdy_q && clr_rdy && wr_idx == last) |=> rdy_q);

endmodule

// File: rtl/uart_rx_monitor.sv
module uart_rx_monitor
    import urxm_pkg::*;
#(
    parameter int NBYTES     = 4,
    parameter int OS         = 16,
    parameter int STUCK_BITS = 100
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         rx_i,
    input  logic                                         os_tick_i,
    input  logic                                         init_i,
    input  logic                                         sleep_i,
    input  logic                                         par_en_i,
    input  logic [((NBYTES > 1) ? $clog2(NBYTES) : 1)-1:0] len_i,
    input  logic                                         lock_i,
    input  logic                                         rx_ie_i,
    input  logic                                         err_ie_i,
    input  logic                                         wake_ie_i,
    input  logic [6+NBYTES-1:0]                          clr_i,
    output logic [6+NBYTES-1:0]                          status_o,
    output logic [8*NBYTES-1:0]                          data_o,
    output logic                                         irq_rx_o,
    output logic                                         irq_err_o,
    output logic                                         irq_wake_o
);
    localparam int SW = 6 + NBYTES;

    logic              rx_m, rx_s;
    rx_byte_t          rbyte;
    logic              byte_v;
    logic              sz_set, wake_set;
    logic              rdy, ovr;
    logic [NBYTES-1:0] par;
    logic              fe_q, sz_q, wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rx_i;
            rx_s <= rx_m;
        end
    end

    urxm_sampler #(.OS(OS)) i_sampler (
        .clk(clk), .rst(rst), .tick(os_tick_i), .rx_s(rx_s),
        .par_en(par_en_i), .byte_o(rbyte), .byte_v_o(byte_v)
    );

    urxm_watch #(.OS(OS), .STUCK_BITS(STUCK_BITS)) i_watch (
        .clk(clk), .rst(rst), .tick(os_tick_i), .rx_s(rx_s),
        .sleep(sleep_i), .sz_set_o(sz_set), .wake_set_o(wake_set)
    );

    urxm_buffer #(.NBYTES(NBYTES)) i_buffer (
        .clk(clk), .rst(rst), .init(init_i), .byte_v(byte_v), .byte_i(rbyte),
        .len_i(len_i), .lock_i(lock_i), .clr_rdy(clr_i[ST_RDY]),
        .clr_ovr(clr_i[ST_OVR]), .clr_par(clr_i[ST_PAR0 +: NBYTES]),
        .rdy_o(rdy), .ovr_o(ovr), .par_o(par), .data_o(data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fe_q   <= 1'b0;
            sz_q   <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            fe_q   <= (fe_q & ~clr_i[ST_FRM]) | (byte_v && rbyte.frm_err);
            sz_q   <= (sz_q & ~clr_i[ST_SZ]) | sz_set;
            wake_q <= init_i ? 1'b0 : ((wake_q & ~clr_i[ST_WAKE]) | wake_set);
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[ST_RDY]            = rdy;
        status_o[ST_FRM]            = fe_q;
        status_o[ST_OVR]            = ovr;
        status_o[ST_SZ]             = sz_q;
        status_o[ST_WAKE]           = wake_q;
        status_o[ST_PIN]            = rx_s;
        status_o[ST_PAR0 +: NBYTES] = par;
    end

    assign irq_rx_o   = rdy && rx_ie_i;
    assign irq_err_o  = (fe_q || ovr || sz_q) && err_ie_i;
    assign irq_wake_o = wake_q && wake_ie_i;

    // R4: a bad stop bit is always recorded
    p_frm_set_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_v && rbyte.frm_err) |=> fe_q);
    // R8: an edge in sleep sets the wake-up flag
    p_wake_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wake_set && !init_i) |=> wake_q);
    // R7: stuck-low rises only out of a low line
    p_sz_low_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sz_q) |-> $past(!rx_s));
    // R5: parity flags alone never interrupt
    p_par_noirq_r5: assert property (@(posedge clk) disable iff (rst)
        (!fe_q && !ovr && !sz_q) |-> !irq_err_o);

    initial begin
        if (SW != $bits(status_o)) $error("status width mismatch");
    end

endmodule

// File: tb/test_uart_rx_monitor.sv
module test_uart_rx_monitor;
    localparam int CLK_P = 10;
    localparam int BIT   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx = 1'b1;
    logic        init = 1'b0, sleep = 1'b0, par_en = 1'b0, lock = 1'b0;
    logic [1:0]  len = 2'd0;
    logic        rx_ie = 1'b0, err_ie = 1'b0, wake_ie = 1'b0;
    logic [9:0]  clr = '0;
    logic [9:0]  status;
    logic [31:0] data;
    logic        irq_rx, irq_err, irq_wake;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    bit done     = 0;

    always #(CLK_P / 2) clk = ~clk;

    uart_rx_monitor i_uart_rx_monitor (
        .clk(clk), .rst(rst), .rx_i(rx), .os_tick_i(1'b1), .init_i(init),
        .sleep_i(sleep), .par_en_i(par_en), .len_i(len), .lock_i(lock),
        .rx_ie_i(rx_ie), .err_ie_i(err_ie), .wake_ie_i(wake_ie), .clr_i(clr),
        .status_o(status), .data_o(data), .irq_rx_o(irq_rx),
        .irq_err_o(irq_err), .irq_wake_o(irq_wake)
    );

    typedef struct {
        logic [31:0] data;
        logic [31:0] mask;
        logic [3:0]  par;
    } exp_t;

    exp_t sb_q[$];
    bit   mon_en = 1;
    logic prev_rdy = 1'b0;
    bit   seen_fe = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d, input logic [31:0] m, input logic [3:0] p);
        exp_t e;
        e.data = d; e.mask = m; e.par = p;
        sb_q.push_back(e);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        rx = 1'b0; wait_n(BIT);
        for (int i = 0; i < 8; i++) begin
            rx = d[i]; wait_n(BIT);
        end
        if (par_en) begin
            rx = (^d) ^ bad_par; wait_n(BIT);
        end
        if (bad_stop) begin
            rx = 1'b0; wait_n(12); rx = 1'b1; wait_n(4);
        end else begin
            rx = 1'b1; wait_n(BIT);
        end
        rx = 1'b1; wait_n(8);
    endtask

    task automatic clear(input logic [9:0] bits);
        clr = bits; wait_n(1); clr = '0; wait_n(1);
    endtask

    // scoreboard monitor: compares buffer on every rising ready
    always @(negedge clk) begin
        if (!rst && mon_en && status[0] && !prev_rdy) begin
            if (sb_q.size() == 0) begin
                chk("R3 unexpected ready", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R3 buffer data", data & e.mask, e.data);
                chk("R5 parity flags", {28'd0, status[9:6]}, {28'd0, e.par});
            end
        end
        prev_rdy <= status[0];
        if (status[1]) seen_fe <= 1;
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss_cnt++;
        vec_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R1 reset state
        chk("R1 reset status", {22'd0, status}, 32'h020);
        chk("R11 reset irqs", {29'd0, irq_rx, irq_err, irq_wake}, 32'd0);

        // R1 pin mirror (short low pulse, rejected as a start)
        rx = 1'b0; wait_n(3);
        chk("R1 pin low", {31'd0, status[5]}, 32'd0);
        rx = 1'b1; wait_n(40);
        chk("R1 pin high", {31'd0, status[5]}, 32'd1);
        // R2 glitch stores nothing; R8 no wake outside sleep
        chk("R2 glitch ignored / R8 no wake", {22'd0, status}, 32'h020);

        // R2/R3/R11 single byte
        rx_ie = 1'b1; err_ie = 1'b1; wake_ie = 1'b1;
        push(32'h0000_00A5, 32'h0000_00FF, 4'b0000);
        send(8'hA5, 0, 0);
        wait_n(2);
        chk("R11 irq_rx", {31'd0, irq_rx}, 32'd1);
        clear(10'h001);
        chk("R10 ready cleared", {31'd0, status[0]}, 32'd0);

        // R3/R5 four-byte batch, byte 2 bad parity
        par_en = 1'b1; len = 2'd3;
        push(32'h3C81_7E12, 32'hFFFF_FFFF, 4'b0100);
        send(8'h12, 0, 0); send(8'h7E, 0, 0); send(8'h81, 1, 0);
        chk("R3 not ready early", {31'd0, status[0]}, 32'd0);
        send(8'h3C, 0, 0);
        wait_n(2);
        chk("R5 parity no irq", {31'd0, irq_err}, 32'd0);
        clear(10'h3FF);
        chk("R10 all cleared", {22'd0, status}, 32'h020);

        // R4 framing error
        len = 2'd0;
        push(32'h0000_00F0, 32'h0000_00FF, 4'b0000);
        send(8'hF0, 0, 1);
        wait_n(2);
        chk("R4 framing flag", {31'd0, status[1]}, 32'd1);
        chk("R11 irq_err", {31'd0, irq_err}, 32'd1);
        clear(10'h3FF);

        // R6 overwrite then lock
        par_en = 1'b0; lock = 1'b0;
        push(32'h0000_00A1, 32'h0000_00FF, 4'b0000);
        send(8'hA1, 0, 0);
        send(8'hB2, 0, 0);
        wait_n(2);
        chk("R6 overrun flag", {31'd0, status[2]}, 32'd1);
        chk("R6 overwrite data", {24'd0, data[7:0]}, 32'hB2);
        chk("R6 ready kept", {31'd0, status[0]}, 32'd1);
        clear(10'h3FF);
        lock = 1'b1;
        push(32'h0000_00C3, 32'h0000_00FF, 4'b0000);
        send(8'hC3, 0, 0);
        send(8'hD4, 0, 0);
        wait_n(2);
        chk("R6 lock overrun", {31'd0, status[2]}, 32'd1);
        chk("R6 lock keeps data", {24'd0, data[7:0]}, 32'hC3);
        clear(10'h3FF);
        lock = 1'b0;

        // R8 wake in sleep, R9 init clears ready and wake
        push(32'h0000_0066, 32'h0000_00FF, 4'b0000);
        send(8'h66, 0, 0);
        sleep = 1'b1;
        rx = 1'b0; wait_n(3); rx = 1'b1; wait_n(6);
        chk("R8 wake flag", {31'd0, status[4]}, 32'd1);
        chk("R8 irq_wake", {31'd0, irq_wake}, 32'd1);
        init = 1'b1; wait_n(3); init = 1'b0; wait_n(1);
        chk("R9 init clears", {22'd0, status}, 32'h020);
        sleep = 1'b0;

        // R9 partial fill discarded by init
        len = 2'd3;
        send(8'h11, 0, 0);
        init = 1'b1; wait_n(2); init = 1'b0; wait_n(1);
        push(32'h2423_2221, 32'hFFFF_FFFF, 4'b0000);
        send(8'h21, 0, 0); send(8'h22, 0, 0); send(8'h23, 0, 0); send(8'h24, 0, 0);
        wait_n(2);
        clear(10'h3FF);

        // R7 stuck low
        mon_en = 0; len = 2'd0;
        rx = 1'b0; wait_n(1500);
        chk("R7 not yet stuck", {31'd0, status[3]}, 32'd0);
        rx = 1'b1; wait_n(60);
        rx = 1'b0; wait_n(1700);
        chk("R7 stuck flag", {31'd0, status[3]}, 32'd1);
        clear(10'h008);
        wait_n(1700);
        chk("R7 fires once", {31'd0, status[3]}, 32'd0);
        rx = 1'b1; wait_n(200);
        clear(10'h3FF);
        mon_en = 1;
        wait_n(2);

        // R10 set wins against a held clear
        seen_fe = 0;
        clr[1] = 1'b1;
        push(32'h0000_000F, 32'h0000_00FF, 4'b0000);
        send(8'h0F, 0, 1);
        wait_n(2);
        clr[1] = 1'b0;
        wait_n(1);
        chk("R10 set seen under clear", {31'd0, seen_fe}, 32'd1);
        chk("R10 cleared afterwards", {31'd0, status[1]}, 32'd0);
        clear(10'h3FF);

        wait_n(4);
        chk("R3 scoreboard drained", sb_q.size(), 32'd0);
        report();
    end

endmodule